// File: doc/BRIEF.md
# Reset Strap Latch and Mode Decoder

This block samples the board-level configuration straps of a small power-management and general-purpose I/O device while its synchronous active-low reset is held. From a single mode pin and the live power-good input it decodes one of three operating modes: general-purpose only, power-management, or alternate power-management. In the same reset window it captures five hardware identification straps and a three-bit bus address select code. Every captured value is held once reset is released, so the pins that carried the straps can be driven as outputs afterwards.

From the held mode the block produces, for each of the twenty pins, a default function code and a default output enable. The output enables of the sixteen core pins are also gated by the live power-good input and by reset. The four power-control pins are the only pins that may drive while power is not yet good. The held address code is mapped to a 7-bit serial-bus slave address, so that up to six devices can share one bus.

Top module: `strap_mode_latch`

## Requirements
- R1: The mode code (op_mode_o) is 0 (general-purpose only) when the mode pin is low, whatever power-good is; 1 (power-management) when the mode pin is high and power-good is low; 2 (alternate power-management) when both are high. Code 3 never appears.
- R2: On every clock edge with rst_n low, the mode, the ID straps and the address code are sampled. The values sampled at the last such edge are held while rst_n stays high, and later changes of the mode pin, the straps or power-good do not alter op_mode_o, id_reg_o or slave_addr_o.
- R3: id_reg_o bit k holds id_strap_i bit k for k = 0..4. In power-management mode, bits 0 and 1 read 0 because those pins drive outputs in that mode.
- R4: Address codes 0 to 5 give slave_addr_o = 0x2C + code. Codes 6 and 7 give 0x2C.
- R5: gpio_count_o is 20 in general-purpose only mode and 16 in both power-management modes.
- R6: pin_func_o[2i+1:2i] is the default function of pin i, with 0 = general input, 1 = dedicated function and 2 = power control. In power-management mode pins 0 (event output), 1 (wake output) and 15 (button input) are 1. In both power-management modes pins 16 to 19 are 2. All other cases are 0.
- R7: The default output enables (pin_oe_o bit i = 1 means that pin i drives) are pins 0, 1 and 16 to 19 in power-management mode, pins 16 to 19 in alternate power-management mode, and none in general-purpose only mode.
- R8: While pwr_good_i is low, pin_oe_o[15:0] is 0 in the same cycle, pins 16 to 19 keep their default enables, and the held mode is unchanged.
- R9: While rst_n is low, pin_oe_o[15:0] is 0, so that the strap pins float to their pull resistors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| mode_pin_i | input | 1 | Mode strap pin |
| pwr_good_i | input | 1 | Host power-good indication, live |
| id_strap_i | input | 5 | Hardware ID straps from pins 0 to 4 |
| addr_strap_i | input | 3 | Bus address select straps |
| op_mode_o | output | 2 | Held mode code |
| gpio_count_o | output | 5 | Number of general-purpose pins in the held mode |
| id_reg_o | output | 5 | Held ID register |
| slave_addr_o | output | 7 | Derived 7-bit slave address |
| pin_func_o | output | 40 | Default function code, two bits per pin |
| pin_oe_o | output | 20 | Default output enable per pin after gating |

## Verification
The assertions assume that the reset is low from time zero until the first clock edges, so that every held register has been loaded before a property is enabled. They also assume that the straps and power-good change only between clock edges. The bench drives all inputs on the falling edge. Before each boot it holds reset for several cycles of random strap noise, so that only the final sample should matter. After reset it scrambles every strap and toggles power-good, which tests the hold and gating rules under inputs the assertions allow.

// File: rtl/strap_cfg_pkg.sv
// Shared types for the strap latch: operating mode and per-pin function codes.
// Assumes the encodings below are decoded unchanged by pin-mux logic elsewhere.
package strap_cfg_pkg;

    typedef enum logic [1:0] {
        MODE_GPIO_ONLY = 2'd0,
        MODE_PMU       = 2'd1,
        MODE_ALT_PMU   = 2'd2
    } op_mode_e;

    typedef enum logic [1:0] {
        PIN_FN_GPIN    = 2'd0,
        PIN_FN_SPECIAL = 2'd1,
        PIN_FN_PWRCTL  = 2'd2
    } pin_fn_e;

endpackage

// File: rtl/strap_capture.sv
// Generic strap register: it follows its input on every clock edge while the
// active-low reset is asserted and holds afterwards.
// Assumes that d_i is stable around the clock edges.
module strap_capture #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Sample while in reset; otherwise keep the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= d_i;
        else        q_o <= q_o;
    end

endmodule

// File: rtl/strap_mode_decode.sv
// Mode decoder: it turns the mode pin and power-good into the next mode code and
// derives the general-purpose pin count from the held mode.
// Assumes that the held mode comes from the strap register in the parent.
module strap_mode_decode
    import strap_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_PC   = 4,
    parameter int CNT_W    = $clog2(NUM_PINS + 1)
) (
    input  logic             mode_pin_i,
    input  logic             pwr_good_i,
    input  op_mode_e         held_mode_i,
    output op_mode_e         mode_next_o,
    output logic [CNT_W-1:0] gpio_count_o
);

    localparam int CORE_PINS = NUM_PINS - NUM_PC;

    // Two-pin mode decode.
    always_comb begin
        if (!mode_pin_i)     mode_next_o = MODE_GPIO_ONLY;
        else if (pwr_good_i) mode_next_o = MODE_ALT_PMU;
        else                 mode_next_o = MODE_PMU;
    end

    // Pins available as general-purpose I/O in the held mode.
    always_comb begin
        if (held_mode_i == MODE_GPIO_ONLY) gpio_count_o = CNT_W'(NUM_PINS);
        else                               gpio_count_o = CNT_W'(CORE_PINS);
    end

endmodule

// File: rtl/strap_addr_map.sv
// Address mapper: a held select code maps to a consecutive slave address;
// codes at or above NUM_ADDR fall back to the base address.
// Assumes ADDR_BASE + NUM_ADDR - 1 fits in ADDR_W bits.
module strap_addr_map #(
    parameter int              SEL_W     = 3,
    parameter int              NUM_ADDR  = 6,
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h2C
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [SEL_W:0] LIMIT = (SEL_W + 1)'(NUM_ADDR);

    // Range check, then offset from the base.
    always_comb begin
        if ({1'b0, sel_i} < LIMIT) addr_o = ADDR_BASE + ADDR_W'(sel_i);
        else                       addr_o = ADDR_BASE;
    end

endmodule

// File: rtl/pin_default_gen.sv
// Per-pin default generator: it gives each pin a function code and an output
// enable for the held mode. Core-pin enables are gated by power-good and by reset.
// The top NUM_PC pins are power control and are never gated.
// Assumes that EVT_PIN, WAKE_PIN and BTN_PIN are core pins.
module pin_default_gen
    import strap_cfg_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int NUM_PC   = 4,
    parameter int EVT_PIN  = 0,
    parameter int WAKE_PIN = 1,
    parameter int BTN_PIN  = 15
) (
    input  logic                  rst_n,
    input  op_mode_e              mode_i,
    input  logic                  pwr_good_i,
    output logic [2*NUM_PINS-1:0] func_o,
    output logic [NUM_PINS-1:0]   oe_o
);

    localparam int CORE_PINS = NUM_PINS - NUM_PC;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_fn_e fn;
        logic    drive;

        if (i >= CORE_PINS) begin : g_pwr
            // Power-control pins take over in both management modes.
            always_comb begin
                if (mode_i == MODE_GPIO_ONLY) begin
                    fn    = PIN_FN_GPIN;
                    drive = 1'b0;
                end else begin
                    fn    = PIN_FN_PWRCTL;
                    drive = 1'b1;
                end
            end
            assign oe_o[i] = drive;
        end else begin : g_core
            // Core pins: dedicated functions exist only in management mode.
            always_comb begin
                fn    = PIN_FN_GPIN;
                drive = 1'b0;
                if (mode_i == MODE_PMU) begin
                    if (i == EVT_PIN || i == WAKE_PIN) begin
                        fn    = PIN_FN_SPECIAL;
                        drive = 1'b1;
                    end else if (i == BTN_PIN) begin
                        fn    = PIN_FN_SPECIAL;
                    end
                end
            end
            assign oe_o[i] = drive & pwr_good_i & rst_n;
        end

        assign func_o[2*i +: 2] = fn;
    end

endmodule

// File: rtl/strap_mode_latch.sv
// Top of the strap latch: captures mode, ID and address straps during reset,
// holds them, and publishes the derived mode, address and pin defaults.
// Assumes a synchronous active-low reset held for at least one clock edge.
module strap_mode_latch
    import strap_cfg_pkg::*;
#(
    parameter int              NUM_PINS  = 20,
    parameter int              NUM_PC    = 4,
    parameter int              NUM_ID    = 5,
    parameter int              SEL_W     = 3,
    parameter int              NUM_ADDR  = 6,
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h2C,
    parameter int              EVT_PIN   = 0,
    parameter int              WAKE_PIN  = 1,
    parameter int              BTN_PIN   = 15,
    parameter int              CNT_W     = $clog2(NUM_PINS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_pin_i,
    input  logic                  pwr_good_i,
    input  logic [NUM_ID-1:0]     id_strap_i,
    input  logic [SEL_W-1:0]      addr_strap_i,
    output logic [1:0]            op_mode_o,
    output logic [CNT_W-1:0]      gpio_count_o,
    output logic [NUM_ID-1:0]     id_reg_o,
    output logic [ADDR_W-1:0]     slave_addr_o,
    output logic [2*NUM_PINS-1:0] pin_func_o,
    output logic [NUM_PINS-1:0]   pin_oe_o
);

    // Bits cleared in the ID capture when those pins are outputs by default.
    function automatic logic [NUM_ID-1:0] pmu_id_mask();
        logic [NUM_ID-1:0] m;
        m           = '1;
        m[EVT_PIN]  = 1'b0;
        m[WAKE_PIN] = 1'b0;
        return m;
    endfunction

    localparam logic [NUM_ID-1:0] PMU_ID_MASK = pmu_id_mask();

    op_mode_e          mode_next;
    op_mode_e          mode_held;
    logic [1:0]        mode_q;
    logic [NUM_ID-1:0] id_d;
    logic [SEL_W-1:0]  sel_q;

    strap_mode_decode #(
        .NUM_PINS (NUM_PINS),
        .NUM_PC   (NUM_PC),
        .CNT_W    (CNT_W)
    ) u_decode (
        .mode_pin_i   (mode_pin_i),
        .pwr_good_i   (pwr_good_i),
        .held_mode_i  (mode_held),
        .mode_next_o  (mode_next),
        .gpio_count_o (gpio_count_o)
    );

    // ID capture value masked by the mode decoded in the same cycle.
    always_comb begin
        if (mode_next == MODE_PMU) id_d = id_strap_i & PMU_ID_MASK;
        else                       id_d = id_strap_i;
    end

    strap_capture #(.W(2)) u_mode_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mode_next),
        .q_o   (mode_q)
    );

    strap_capture #(.W(NUM_ID)) u_id_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (id_d),
        .q_o   (id_reg_o)
    );

    strap_capture #(.W(SEL_W)) u_sel_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (addr_strap_i),
        .q_o   (sel_q)
    );

    assign mode_held = op_mode_e'(mode_q);
    assign op_mode_o = mode_q;

    strap_addr_map #(
        .SEL_W     (SEL_W),
        .NUM_ADDR  (NUM_ADDR),
        .ADDR_W    (ADDR_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_addr (
        .sel_i  (sel_q),
        .addr_o (slave_addr_o)
    );

    pin_default_gen #(
        .NUM_PINS (NUM_PINS),
        .NUM_PC   (NUM_PC),
        .EVT_PIN  (EVT_PIN),
        .WAKE_PIN (WAKE_PIN),
        .BTN_PIN  (BTN_PIN)
    ) u_pins (
        .rst_n      (rst_n),
        .mode_i     (mode_held),
        .pwr_good_i (pwr_good_i),
        .func_o     (pin_func_o),
        .oe_o       (pin_oe_o)
    );

endmodule

// File: rtl/strap_mode_latch_chk.sv
// Assertion checker for the strap latch, bound to every instance of the top.
// Assumes that reset is low from time zero.
module strap_mode_latch_chk #(
    parameter int              NUM_PINS  = 20,
    parameter int              NUM_PC    = 4,
    parameter int              NUM_ID    = 5,
    parameter int              NUM_ADDR  = 6,
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h2C,
    parameter int              EVT_PIN   = 0,
    parameter int              WAKE_PIN  = 1,
    parameter int              CNT_W     = $clog2(NUM_PINS + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pwr_good_i,
    input logic [1:0]            op_mode_o,
    input logic [CNT_W-1:0]      gpio_count_o,
    input logic [NUM_ID-1:0]     id_reg_o,
    input logic [ADDR_W-1:0]     slave_addr_o,
    input logic [2*NUM_PINS-1:0] pin_func_o,
    input logic [NUM_PINS-1:0]   pin_oe_o
);

    localparam int              CORE_PINS = NUM_PINS - NUM_PC;
    localparam logic [ADDR_W:0] ADDR_TOP  = (ADDR_W + 1)'(ADDR_BASE) + (ADDR_W + 1)'(NUM_ADDR);

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode_o != 2'd3);

    assert_hold_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(op_mode_o) && $stable(id_reg_o) && $stable(slave_addr_o)));

    assert_pmu_id_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode_o == 2'd1) |-> (!id_reg_o[EVT_PIN] && !id_reg_o[WAKE_PIN]));

    assert_addr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_addr_o >= ADDR_BASE) && ({1'b0, slave_addr_o} < ADDR_TOP));

    assert_gpio_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode_o == 2'd0) == (gpio_count_o == CNT_W'(NUM_PINS)));

    assert_pc_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode_o != 2'd0) |-> (pin_func_o[2*NUM_PINS-1 -: 2] == 2'd2));

    assert_pc_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode_o != 2'd0) |-> (&pin_oe_o[NUM_PINS-1 -: NUM_PC]));

    assert_pg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |-> (pin_oe_o[CORE_PINS-1:0] == '0));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (pin_oe_o[CORE_PINS-1:0] == '0));

endmodule

bind strap_mode_latch strap_mode_latch_chk #(
    .NUM_PINS  (NUM_PINS),
    .NUM_PC    (NUM_PC),
    .NUM_ID    (NUM_ID),
    .NUM_ADDR  (NUM_ADDR),
    .ADDR_W    (ADDR_W),
    .ADDR_BASE (ADDR_BASE),
    .EVT_PIN   (EVT_PIN),
    .WAKE_PIN  (WAKE_PIN),
    .CNT_W     (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good_i   (pwr_good_i),
    .op_mode_o    (op_mode_o),
    .gpio_count_o (gpio_count_o),
    .id_reg_o     (id_reg_o),
    .slave_addr_o (slave_addr_o),
    .pin_func_o   (pin_func_o),
    .pin_oe_o     (pin_oe_o)
);

// File: tb/tb_strap_mode_latch.sv
// Bench for the strap latch: directed boots plus seeded random boots, with
// expected values from bench functions.
module tb_strap_mode_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pin = 1'b0;
    logic        pwr_good = 1'b0;
    logic [4:0]  id_strap = '0;
    logic [2:0]  addr_strap = '0;
    logic [1:0]  op_mode;
    logic [4:0]  gpio_count;
    logic [4:0]  id_reg;
    logic [6:0]  slave_addr;
    logic [39:0] pin_func;
    logic [19:0] pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    strap_mode_latch dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_pin_i   (mode_pin),
        .pwr_good_i   (pwr_good),
        .id_strap_i   (id_strap),
        .addr_strap_i (addr_strap),
        .op_mode_o    (op_mode),
        .gpio_count_o (gpio_count),
        .id_reg_o     (id_reg),
        .slave_addr_o (slave_addr),
        .pin_func_o   (pin_func),
        .pin_oe_o     (pin_oe)
    );

    function automatic logic [1:0] exp_mode(input logic m, input logic pg);
        if (!m) return 2'd0;
        return pg ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [4:0] exp_id(input logic [1:0] md, input logic [4:0] id);
        return (md == 2'd1) ? (id & 5'b11100) : id;
    endfunction

    function automatic logic [6:0] exp_addr(input logic [2:0] sel);
        return (sel < 3'd6) ? 7'h2C + 7'(sel) : 7'h2C;
    endfunction

    function automatic logic [4:0] exp_count(input logic [1:0] md);
        return (md == 2'd0) ? 5'd20 : 5'd16;
    endfunction

    function automatic logic [39:0] exp_func(input logic [1:0] md);
        logic [39:0] f = '0;
        if (md == 2'd1) begin
            f[1:0]   = 2'd1;
            f[3:2]   = 2'd1;
            f[31:30] = 2'd1;
        end
        if (md != 2'd0)
            for (int i = 16; i < 20; i++) f[2*i +: 2] = 2'd2;
        return f;
    endfunction

    function automatic logic [19:0] exp_oe(input logic [1:0] md, input logic pg, input logic rs);
        logic [19:0] o = '0;
        if (md != 2'd0) o[19:16] = 4'hF;
        if (md == 2'd1 && pg && rs) o[1:0] = 2'b11;
        return o;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One boot: noisy reset, final strap values, release, scramble, gate test.
    task automatic boot(input logic m, input logic pg, input logic [4:0] id, input logic [2:0] sel);
        logic [1:0] em;
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            mode_pin   = 1'($urandom);
            pwr_good   = 1'($urandom);
            id_strap   = 5'($urandom);
            addr_strap = 3'($urandom);
            @(negedge clk);
        end
        mode_pin = m; pwr_good = pg; id_strap = id; addr_strap = sel;
        @(negedge clk);
        em = exp_mode(m, pg);
        chk("R9 core oe in reset", 64'(pin_oe[15:0]), 64'(0));
        chk("R1 mode decode", 64'(op_mode), 64'(em));
        rst_n = 1'b1;
        mode_pin   = ~m;
        id_strap   = ~id;
        addr_strap = sel ^ 3'b101;
        repeat (2) @(negedge clk);
        chk("R2 mode held", 64'(op_mode), 64'(em));
        chk("R3 id register", 64'(id_reg), 64'(exp_id(em, id)));
        chk("R4 slave address", 64'(slave_addr), 64'(exp_addr(sel)));
        chk("R5 gpio count", 64'(gpio_count), 64'(exp_count(em)));
        chk("R6 pin functions", 64'(pin_func), 64'(exp_func(em)));
        chk("R7 default oe", 64'(pin_oe), 64'(exp_oe(em, pg, 1'b1)));
        pwr_good = ~pg;
        @(negedge clk);
        chk("R8 oe after power-good change", 64'(pin_oe), 64'(exp_oe(em, ~pg, 1'b1)));
        chk("R2 mode ignores power-good", 64'(op_mode), 64'(em));
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R8 core oe with power-good low", 64'(pin_oe[15:0]), 64'(0));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (2) @(negedge clk);
        // Directed corners: every mode, address edge codes.
        boot(1'b0, 1'b0, 5'b10101, 3'd0);
        boot(1'b0, 1'b1, 5'b11111, 3'd5);
        boot(1'b1, 1'b0, 5'b11111, 3'd6);
        boot(1'b1, 1'b1, 5'b01011, 3'd7);
        boot(1'b1, 1'b0, 5'b00011, 3'd3);
        // Random boots.
        for (int n = 0; n < 40; n++)
            boot(1'($urandom), 1'($urandom), 5'($urandom), 3'($urandom));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule